// File: doc/BRIEF.md
# Register-Addressed Branch Processor Core

This block is a small single-cycle processor that executes one 16-bit instruction per clock. It holds a program counter, an instruction store, sixteen 32-bit general registers, one adder, a word-addressed data store, an input port with a valid/acknowledge handshake and an output port with a one-cycle strobe. Every branch takes its destination from a register rather than from an offset inside the instruction.

The instruction store is written through a loading port, normally while reset is held low. After reset is released the core fetches from address zero and runs until it meets a halt instruction. An input instruction waits in place until the port offers valid data. Typical use is a tiny sequencer or teaching core that reads an operand, computes with repeated addition, and writes results out.

Top module: `nib_cpu`

## Requirements
- R1: An instruction word holds the opcode in bits 15:12 and register fields f1, f2 and f3 in bits 11:8, 7:4 and 3:0; the LDI immediate occupies bits 7:0. Opcodes: 0000 halt, 0001 load, 0010 store, 0011 add, 0100 branch-if-equal, 0101 branch-if-not-equal, 0110 branch-always, 1000 input, 1001 output, 1010 LDI, 1011 clear; every other code is a no-op.
- R2: While rst_ni is low the PC, all registers, out_valid_o, out_data_o and halted_o are zero.
- R3: Add writes R[f1] + R[f2] (modulo 2^32) into R[f3].
- R4: Load writes the data word at address R[f1] into R[f2]; store writes R[f2] into the data word at address R[f1]; the address is the low bits of the register.
- R5: Branch-if-equal sets the PC to the low bits of R[f3] when R[f1] equals R[f2], branch-if-not-equal when they differ; otherwise the PC steps by one.
- R6: Branch-always sets the PC to the low bits of R[f1].
- R7: LDI writes the 8-bit immediate zero-extended into R[f1]; clear writes zero into R[f1].
- R8: Input holds the PC while in_valid_i is low; when in_valid_i is high, in_ack_o is high in that same cycle and in_data_i is written into R[f1] at the clock edge.
- R9: Output drives R[f1] on out_data_o with out_valid_o high for exactly the cycle after the output instruction executes; back-to-back outputs give back-to-back strobes.
- R10: Halt freezes the PC and sets halted_o from the next cycle on until reset; no-op opcodes change no register or memory.
- R11: Every other instruction advances the PC by one, wrapping from the last instruction address to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_we_i | input | 1 | Instruction store write enable |
| prog_addr_i | input | IMEM_AW | Instruction store write address |
| prog_data_i | input | 16 | Instruction word to write |
| in_data_i | input | DW | Input port data |
| in_valid_i | input | 1 | Input port data valid |
| in_ack_o | output | 1 | Input data taken at this clock edge |
| out_data_o | output | DW | Output port data |
| out_valid_o | output | 1 | Output strobe, one cycle per output instruction |
| pc_o | output | IMEM_AW | Current program counter |
| halted_o | output | 1 | Core has executed a halt |

## Verification
The case where two functions share a cycle is an output instruction followed directly by an input instruction whose data is withheld: the output strobe of the first appears in the very cycle the second is stalling. The bench withholds in_valid_i for several cycles at that point and compares PC, strobe, data and acknowledge against a behavioural instruction-level model every cycle, so the strobe must last exactly one cycle while the PC stays frozen. Two consecutive output instructions provoke the opposite case, where strobes must run back to back.

// File: rtl/nib_pkg.sv
package nib_pkg;

  typedef enum logic [3:0] {
    OP_HALT  = 4'b0000,
    OP_LOAD  = 4'b0001,
    OP_STORE = 4'b0010,
    OP_ADD   = 4'b0011,
    OP_BEQ   = 4'b0100,
    OP_BNE   = 4'b0101,
    OP_BR    = 4'b0110,
    OP_IN    = 4'b1000,
    OP_OUT   = 4'b1001,
    OP_LDI   = 4'b1010,
    OP_CLR   = 4'b1011
  } op_e;

  typedef enum logic [2:0] {
    WB_ADD, WB_LOAD, WB_IMM, WB_ZERO, WB_IN
  } wb_sel_e;

  typedef enum logic [1:0] {
    BR_NONE, BR_EQ, BR_NE, BR_ALL
  } br_kind_e;

  typedef struct packed {
    logic       rf_we;
    wb_sel_e    wb_sel;
    logic [3:0] waddr;
    logic       is_in;
    logic       is_out;
    logic       is_store;
    logic       is_halt;
    br_kind_e   br;
  } ctrl_t;

endpackage

// File: rtl/nib_decode.sv
module nib_decode
  import nib_pkg::*;
(
  input  logic [15:0] instr_i,
  output ctrl_t       ctrl_o
);

  logic [3:0] op;
  logic [3:0] f1, f2, f3;

  assign op = instr_i[15:12];
  assign f1 = instr_i[11:8];
  assign f2 = instr_i[7:4];
  assign f3 = instr_i[3:0];

  always_comb begin
    ctrl_o = '{rf_we: 1'b0, wb_sel: WB_ADD, waddr: f1, is_in: 1'b0,
               is_out: 1'b0, is_store: 1'b0, is_halt: 1'b0, br: BR_NONE};
    case (op)
      OP_HALT:  ctrl_o.is_halt = 1'b1;
      OP_LOAD:  begin ctrl_o.rf_we = 1'b1; ctrl_o.wb_sel = WB_LOAD; ctrl_o.waddr = f2; end
      OP_STORE: ctrl_o.is_store = 1'b1;
      OP_ADD:   begin ctrl_o.rf_we = 1'b1; ctrl_o.wb_sel = WB_ADD; ctrl_o.waddr = f3; end
      OP_BEQ:   ctrl_o.br = BR_EQ;
      OP_BNE:   ctrl_o.br = BR_NE;
      OP_BR:    ctrl_o.br = BR_ALL;
      OP_IN:    begin ctrl_o.rf_we = 1'b1; ctrl_o.wb_sel = WB_IN; ctrl_o.is_in = 1'b1; end
      OP_OUT:   ctrl_o.is_out = 1'b1;
      OP_LDI:   begin ctrl_o.rf_we = 1'b1; ctrl_o.wb_sel = WB_IMM; end
      OP_CLR:   begin ctrl_o.rf_we = 1'b1; ctrl_o.wb_sel = WB_ZERO; end
      default:  ;
    endcase
  end

endmodule

// File: rtl/nib_regfile.sv
module nib_regfile #(
  parameter int DW = 32,
  parameter int RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ra_addr_i,
  input  logic [RW-1:0] rb_addr_i,
  input  logic [RW-1:0] rc_addr_i,
  output logic [DW-1:0] ra_o,
  output logic [DW-1:0] rb_o,
  output logic [DW-1:0] rc_o,
  input  logic          we_i,
  input  logic [RW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i
);

  localparam int NREG = 2 ** RW;

  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign ra_o = regs_q[ra_addr_i];
  assign rb_o = regs_q[rb_addr_i];
  assign rc_o = regs_q[rc_addr_i];

endmodule

// File: rtl/nib_dmem.sv
module nib_dmem #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/nib_cpu.sv
module nib_cpu
  import nib_pkg::*;
#(
  parameter int DW      = 32,
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prog_we_i,
  input  logic [IMEM_AW-1:0] prog_addr_i,
  input  logic [15:0]        prog_data_i,
  input  logic [DW-1:0]      in_data_i,
  input  logic               in_valid_i,
  output logic               in_ack_o,
  output logic [DW-1:0]      out_data_o,
  output logic               out_valid_o,
  output logic [IMEM_AW-1:0] pc_o,
  output logic               halted_o
);

  localparam int IDEPTH = 2 ** IMEM_AW;
  localparam int RW     = 4;
  localparam int IMM_W  = 8;

  logic [15:0]        imem_q [IDEPTH];
  logic [IMEM_AW-1:0] pc_q, pc_d;
  logic               halted_q;
  logic [15:0]        instr;
  ctrl_t              ctrl;
  logic [DW-1:0]      ra, rb, rc, wdata, sum, ld_data, target;
  logic               stall, take, rf_we, seq_op;
  logic               out_valid_q;
  logic [DW-1:0]      out_data_q;

  always_ff @(posedge clk_i) begin
    if (prog_we_i) imem_q[prog_addr_i] <= prog_data_i;
  end

  assign instr = imem_q[pc_q];

  nib_decode i_decode (
    .instr_i (instr),
    .ctrl_o  (ctrl)
  );

  nib_regfile #(.DW(DW), .RW(RW)) i_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_addr_i (instr[11:8]),
    .rb_addr_i (instr[7:4]),
    .rc_addr_i (instr[3:0]),
    .ra_o      (ra),
    .rb_o      (rb),
    .rc_o      (rc),
    .we_i      (rf_we),
    .waddr_i   (ctrl.waddr),
    .wdata_i   (wdata)
  );

  nib_dmem #(.DW(DW), .AW(DMEM_AW)) i_dmem (
    .clk_i   (clk_i),
    .we_i    (ctrl.is_store),
    .addr_i  (ra[DMEM_AW-1:0]),
    .wdata_i (rb),
    .rdata_o (ld_data)
  );

  // single adder, shared by nothing else
  assign sum = ra + rb;

  always_comb begin
    case (ctrl.wb_sel)
      WB_ADD:  wdata = sum;
      WB_LOAD: wdata = ld_data;
      WB_IMM:  wdata = {{(DW-IMM_W){1'b0}}, instr[IMM_W-1:0]};
      WB_IN:   wdata = in_data_i;
      default: wdata = '0;
    endcase
  end

  assign stall = ctrl.is_in && !in_valid_i;
  assign rf_we = ctrl.rf_we && !stall;

  always_comb begin
    case (ctrl.br)
      BR_EQ:   take = (ra == rb);
      BR_NE:   take = (ra != rb);
      BR_ALL:  take = 1'b1;
      default: take = 1'b0;
    endcase
  end

  assign target = (ctrl.br == BR_ALL) ? ra : rc;

  always_comb begin
    if (ctrl.is_halt || stall) pc_d = pc_q;
    else if (take)             pc_d = target[IMEM_AW-1:0];
    else                       pc_d = pc_q + IMEM_AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q        <= '0;
      halted_q    <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      pc_q        <= pc_d;
      halted_q    <= halted_q || ctrl.is_halt;
      out_valid_q <= ctrl.is_out;
      if (ctrl.is_out) out_data_q <= ra;
    end
  end

  assign in_ack_o    = ctrl.is_in && in_valid_i;
  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
  assign pc_o        = pc_q;
  assign halted_o    = halted_q;

  assign seq_op = !ctrl.is_halt && !ctrl.is_in && (ctrl.br == BR_NONE);

  assert_halt_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> halted_q && $stable(pc_q));

  assert_out_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(instr[15:12]) == OP_OUT);

  assert_in_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.is_in && !in_valid_i) |=> $stable(pc_q));

  assert_pc_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_op |=> pc_q == $past(pc_q) + IMEM_AW'(1));

  assert_br_target_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.br == BR_ALL) |=> pc_q == $past(ra[IMEM_AW-1:0]));

endmodule

// File: tb/test_nib_cpu.sv
module test_nib_cpu;

  localparam int DW = 32;
  localparam int AW = 6;
  localparam int DEPTH = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          prog_we_i = 1'b0;
  logic [AW-1:0] prog_addr_i = '0;
  logic [15:0]   prog_data_i = '0;
  logic [DW-1:0] in_data_i = '0;
  logic          in_valid_i = 1'b0;
  logic          in_ack_o, out_valid_o, halted_o;
  logic [DW-1:0] out_data_o;
  logic [AW-1:0] pc_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  nib_cpu #(.DW(DW), .IMEM_AW(AW), .DMEM_AW(AW)) i_nib_cpu (
    .clk_i, .rst_ni, .prog_we_i, .prog_addr_i, .prog_data_i,
    .in_data_i, .in_valid_i, .in_ack_o, .out_data_o, .out_valid_o,
    .pc_o, .halted_o
  );

  // reference model state
  bit [15:0] imem_m [DEPTH];
  bit [31:0] regs_m [16];
  bit [31:0] dmem_m [DEPTH];
  int        pc_m;
  bit        halted_m, ov_m;
  bit [31:0] od_m;
  bit [15:0] w_m;
  int        a_m, b_m, c_m, nxt_m;
  bit        cmp_en = 1'b0;
  bit [31:0] outs [$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [15:0] enc(input int op, input int a, input int b, input int c);
    return {op[3:0], a[3:0], b[3:0], c[3:0]};
  endfunction

  function automatic bit [15:0] ldi(input int r, input int imm);
    return {4'b1010, r[3:0], imm[7:0]};
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_m = 0; halted_m = 0; ov_m = 0; od_m = 0;
      for (int i = 0; i < 16; i++) regs_m[i] = 0;
    end else begin
      w_m = imem_m[pc_m];
      a_m = w_m[11:8]; b_m = w_m[7:4]; c_m = w_m[3:0];
      nxt_m = (pc_m + 1) % DEPTH;
      ov_m = 0;
      case (w_m[15:12])
        4'd0:  begin halted_m = 1; nxt_m = pc_m; end
        4'd1:  regs_m[b_m] = dmem_m[regs_m[a_m] % DEPTH];
        4'd2:  dmem_m[regs_m[a_m] % DEPTH] = regs_m[b_m];
        4'd3:  regs_m[c_m] = regs_m[a_m] + regs_m[b_m];
        4'd4:  if (regs_m[a_m] == regs_m[b_m]) nxt_m = regs_m[c_m] % DEPTH;
        4'd5:  if (regs_m[a_m] != regs_m[b_m]) nxt_m = regs_m[c_m] % DEPTH;
        4'd6:  nxt_m = regs_m[a_m] % DEPTH;
        4'd8:  if (in_valid_i) regs_m[a_m] = in_data_i; else nxt_m = pc_m;
        4'd9:  begin ov_m = 1; od_m = regs_m[a_m]; end
        4'd10: regs_m[a_m] = {24'd0, w_m[7:0]};
        4'd11: regs_m[a_m] = 0;
        default: ;
      endcase
      pc_m = nxt_m;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (cmp_en && rst_ni) begin
      check(pc_o == AW'(pc_m), "R5/R6/R11 pc", pc_o, pc_m);
      check(halted_o == halted_m, "R10 halted", halted_o, halted_m);
      check(out_valid_o == ov_m, "R9 out_valid", out_valid_o, ov_m);
      if (ov_m) check(out_data_o == od_m, "R9 out_data", out_data_o, od_m);
      check(in_ack_o == (imem_m[pc_m][15:12] == 4'd8 && in_valid_i), "R8 in_ack",
            in_ack_o, (imem_m[pc_m][15:12] == 4'd8 && in_valid_i));
      if (out_valid_o) outs.push_back(out_data_o);
    end
  end

  task automatic load(input int addr, input bit [15:0] word);
    @(negedge clk_i);
    prog_we_i = 1'b1; prog_addr_i = AW'(addr); prog_data_i = word;
    imem_m[addr] = word;
    @(negedge clk_i);
    prog_we_i = 1'b0;
  endtask

  task automatic offer(input bit [31:0] val);
    in_valid_i = 1'b1; in_data_i = val;
    #1;
    while (!in_ack_o) begin @(negedge clk_i); #1; end
    @(posedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit [15:0] p1 [28];
    p1 = '{enc(8,1,0,0), enc(11,2,0,0), enc(11,3,0,0), ldi(4,1), ldi(5,6),
           enc(7,0,0,0), enc(3,1,3,3), enc(3,4,2,2), enc(5,1,2,5), enc(9,3,0,0),
           enc(8,7,0,0), enc(2,4,3,0), ldi(8,1), enc(1,8,9,0), ldi(10,8'hFF),
           enc(3,10,10,10), ldi(10,3), enc(9,10,0,0), enc(9,9,0,0), ldi(11,23),
           enc(4,1,4,11), enc(4,9,3,11), enc(9,4,0,0), enc(9,7,0,0), ldi(12,27),
           enc(6,12,0,0), enc(9,4,0,0), enc(0,0,0,0)};
    for (int i = 0; i < DEPTH; i++) dmem_m[i] = 0;

    // program 1 loaded under reset
    for (int i = 0; i < DEPTH; i++) load(i, (i < 28) ? p1[i] : 16'h7000);
    @(negedge clk_i);
    check(pc_o == 0, "R2 reset pc", pc_o, 0);
    check(out_valid_o == 0 && out_data_o == 0, "R2 reset out", out_valid_o, 0);
    check(halted_o == 0, "R2 reset halted", halted_o, 0);

    cmp_en = 1'b1;
    rst_ni = 1'b1;
    fork
      begin
        repeat (5) @(negedge clk_i);
        offer(32'd7);
        wait (pc_o == 10);
        repeat (4) @(negedge clk_i);  // stall IN while OUT strobe is live
        offer(32'h1234_5678);
      end
    join_none
    wait (halted_o);
    repeat (4) @(negedge clk_i);
    check(pc_o == 27, "R10 halt pc frozen", pc_o, 27);
    check(outs.size() == 4, "R9 output count", outs.size(), 4);
    if (outs.size() == 4) begin
      check(outs[0] == 49, "R3 square via add loop", outs[0], 49);
      check(outs[1] == 3, "R7 LDI zero-extends", outs[1], 3);
      check(outs[2] == 49, "R4 store then load", outs[2], 49);
      check(outs[3] == 32'h1234_5678, "R8 second input", outs[3], 32'h1234_5678);
    end

    // program 2: no-op opcodes, reset register state, PC wrap
    cmp_en = 1'b0;
    rst_ni = 1'b0;
    outs.delete();
    for (int i = 0; i < DEPTH; i++) begin
      case (i)
        0: load(i, ldi(1, 8'h5A));
        1: load(i, 16'hC111);
        2: load(i, 16'hF111);
        3: load(i, enc(9,1,0,0));
        4: load(i, enc(9,13,0,0));
        default: load(i, 16'h7000);
      endcase
    end
    @(negedge clk_i);
    check(pc_o == 0 && halted_o == 0, "R2 second reset", pc_o, 0);
    cmp_en = 1'b1;
    rst_ni = 1'b1;
    repeat (140) @(negedge clk_i);
    check(outs.size() == 6, "R11 wrap repeats outputs", outs.size(), 6);
    for (int i = 0; i < outs.size(); i++) begin
      if (i % 2 == 0) check(outs[i] == 32'h5A, "R10 no-op keeps R1", outs[i], 32'h5A);
      else            check(outs[i] == 0, "R2 register cleared", outs[i], 0);
    end
    check(halted_o == 0, "R1 unused codes are not halt", halted_o, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule